// File: doc/BRIEF.md
# Prescaled Timer With Alarm Interrupts

This block keeps a free-running 32-bit timer that advances once every 128 core clocks. It also holds a compare alarm and a small interrupt controller. The timer is advanced by a prescaler tick. On the tick where the timer becomes equal to the alarm value, interrupt source 0 is latched into a 32-bit pending register. Two button inputs are synchronized and edge-detected, and each press latches its own pending bit: bit 17 for the reset button and bit 11 for the power button. Other peripheral event lines enter as single-cycle set pulses.

Pending bits latch whatever the enable register holds. A single interrupt line is raised whenever any pending bit is also enabled. Software reaches the four registers through a simple single-cycle register bus. Writes take effect on the clock edge and reads return data in the same cycle. Writing the timer restarts the prescaler, and pending bits are cleared by writing ones to them.

Top module: `prescaled_alarm_timer`

## Requirements
- R1: After reset the timer, alarm, pending and enable registers all read 0 and `irqOut` is low.
- R2: The timer (offset 0x10) increases by exactly one every 128 clock cycles.
- R3: A bus write to the timer loads the written value and restarts the prescaler, so the next increment comes 128 edges after the write edge.
- R4: Pending bit 0 sets on the prescaler tick where the timer becomes equal to the alarm (offset 0x14). Once cleared, it stays clear while the timer keeps holding that equal value.
- R5: Loading the timer with a value equal to the alarm through a bus write does not set pending bit 0.
- R6: The pending register (offset 0x38) clears each bit written with 1 and keeps each bit written with 0.
- R7: A rising edge on `rstBtn` sets pending bit 17 once. Holding the button high does not set it again after a clear.
- R8: A rising edge on `pwrBtn` sets pending bit 11.
- R9: `irqOut` is high exactly when some pending bit is also set in the enable register (offset 0x3C). Pending bits latch while their enable bit is 0.
- R10: When a hardware set and a clear write hit the same pending bit in the same cycle, the bit ends up set.
- R11: A pulse on `extIrq` sets the matching pending bit. `extIrq` bits 0, 11 and 17 are ignored.
- R12: Reads at any offset other than the four above return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of the access |
| rstBtn | input | 1 | Reset button, asynchronous level |
| pwrBtn | input | 1 | Power button, asynchronous level |
| extIrq | input | 32 | Single-cycle event pulses from other sources |
| irqOut | output | 1 | Combined masked interrupt |

## Verification
If the prescaler count is wrong, the timer increment lands on the wrong edge after a timer write, and a read one cycle early or late shows it within 128 cycles. An alarm compare made on the old timer value, or made on every cycle, shows up as bit 0 set on a timer load or set again after a clear while the timer still equals the alarm. Errors in edge detection or in set-versus-clear priority show in the pending register on the cycle after the event. A wrong mask shows on `irqOut` at once.

// File: rtl/pat_pkg.sv
package pat_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  typedef struct packed {
    logic              wrTimer;
    logic              wrAlarm;
    logic              wrClear;
    logic              wrEnable;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] setMask;
  } patStrobe_t;

  typedef struct packed {
    logic [DATA_W-1:0] timer;
    logic [DATA_W-1:0] alarm;
    logic [DATA_W-1:0] pending;
    logic [DATA_W-1:0] enable;
  } patRegs_t;
endpackage

// File: rtl/pat_btn_edge.sv
module pat_btn_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic btnIn,
  output logic pressPulse
);
  logic [STAGES-1:0] syncChain;
  logic              prevLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      prevLevel <= 1'b0;
    end else begin
      syncChain <= {syncChain[STAGES-2:0], btnIn};
      prevLevel <= syncChain[STAGES-1];
    end
  end

  assign pressPulse = syncChain[STAGES-1] & ~prevLevel;

  // R7
  single_press_chk: assert property (@(posedge clk) disable iff (!rstN)
    pressPulse |=> !pressPulse);
endmodule

// File: rtl/pat_ctrl.sv
module pat_ctrl
  import pat_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter int              RST_BIT     = 17,
  parameter int              PWR_BIT     = 11,
  parameter int              ALARM_BIT   = 0,
  parameter logic [ADDR_W-1:0] OFF_TIMER  = 8'h10,
  parameter logic [ADDR_W-1:0] OFF_ALARM  = 8'h14,
  parameter logic [ADDR_W-1:0] OFF_STATUS = 8'h38,
  parameter logic [ADDR_W-1:0] OFF_ENABLE = 8'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rstBtn,
  input  logic              pwrBtn,
  input  logic [DATA_W-1:0] extIrq,
  input  patRegs_t          regs,
  output patStrobe_t        strb
);
  localparam int NUM_BTN = 2;
  localparam int BTN_POS [NUM_BTN] = '{RST_BIT, PWR_BIT};
  localparam logic [DATA_W-1:0] RESERVED_MASK =
    (DATA_W'(1) << ALARM_BIT) | (DATA_W'(1) << RST_BIT) | (DATA_W'(1) << PWR_BIT);

  logic [NUM_BTN-1:0] btnLevel;
  logic [NUM_BTN-1:0] btnPulse;
  logic [DATA_W-1:0]  btnMask;
  logic               wrAny;

  assign btnLevel = {pwrBtn, rstBtn};

  genvar g;
  generate
    for (g = 0; g < NUM_BTN; g++) begin : gBtn
      pat_btn_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rstN      (rstN),
        .btnIn     (btnLevel[g]),
        .pressPulse(btnPulse[g])
      );
    end
  endgenerate

  always_comb begin
    btnMask = '0;
    for (int i = 0; i < NUM_BTN; i++) begin
      if (btnPulse[i]) btnMask[BTN_POS[i]] = 1'b1;
    end
  end

  assign wrAny = busSel & busWrite;

  always_comb begin
    strb          = '0;
    strb.wdata    = busWdata;
    strb.setMask  = btnMask | (extIrq & ~RESERVED_MASK);
    strb.wrTimer  = wrAny && (busAddr == OFF_TIMER);
    strb.wrAlarm  = wrAny && (busAddr == OFF_ALARM);
    strb.wrClear  = wrAny && (busAddr == OFF_STATUS);
    strb.wrEnable = wrAny && (busAddr == OFF_ENABLE);
  end

  always_comb begin
    busRdata = '0;
    if (busSel && !busWrite) begin
      case (busAddr)
        OFF_TIMER:  busRdata = regs.timer;
        OFF_ALARM:  busRdata = regs.alarm;
        OFF_STATUS: busRdata = regs.pending;
        OFF_ENABLE: busRdata = regs.enable;
        default:    busRdata = '0;
      endcase
    end
  end

  // R12
  one_write_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrTimer, strb.wrAlarm, strb.wrClear, strb.wrEnable}));

  // R11
  reserved_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (btnPulse == '0) |-> ((strb.setMask & RESERVED_MASK) == '0));
endmodule

// File: rtl/pat_datapath.sv
module pat_datapath
  import pat_pkg::*;
#(
  parameter int PRESCALE  = 128,
  parameter int ALARM_BIT = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  patStrobe_t strb,
  output patRegs_t   regs,
  output logic       irqOut
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0]   presc;
  logic              tick;
  logic [DATA_W-1:0] timerQ, alarmQ, pendQ, enQ;
  logic [DATA_W-1:0] timerNext;
  logic              alarmHit;
  logic [DATA_W-1:0] setAll;
  logic [DATA_W-1:0] clrAll;
  logic              pastValid;

  assign tick      = (presc == PS_LAST);
  assign timerNext = timerQ + DATA_W'(1);
  assign alarmHit  = tick && !strb.wrTimer && (timerNext == alarmQ);
  assign setAll    = strb.setMask | (DATA_W'(alarmHit) << ALARM_BIT);
  assign clrAll    = strb.wrClear ? strb.wdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc     <= '0;
      timerQ    <= '0;
      pastValid <= 1'b0;
    end else begin
      pastValid <= 1'b1;
      if (strb.wrTimer) begin
        presc  <= '0;
        timerQ <= strb.wdata;
      end else begin
        presc <= tick ? '0 : presc + PS_W'(1);
        if (tick) timerQ <= timerNext;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmQ <= '0;
      enQ    <= '0;
      pendQ  <= '0;
    end else begin
      if (strb.wrAlarm)  alarmQ <= strb.wdata;
      if (strb.wrEnable) enQ    <= strb.wdata;
      pendQ <= (pendQ & ~clrAll) | setAll;
    end
  end

  assign regs.timer   = timerQ;
  assign regs.alarm   = alarmQ;
  assign regs.pending = pendQ;
  assign regs.enable  = enQ;
  assign irqOut       = |(pendQ & enQ);

  // R2
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !strb.wrTimer && !tick) |=> $stable(timerQ));

  // R3
  timer_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTimer |=> (timerQ == $past(strb.wdata)) && (presc == '0));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setAll != '0) |=> ((pendQ & $past(setAll)) == $past(setAll)));

  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClear |=> ((pendQ & $past(strb.wdata & ~setAll)) == '0));

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (enQ != '0) && (pendQ != '0));

  // R5
  no_alarm_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && strb.wrTimer && !pendQ[ALARM_BIT] && !strb.wrClear) |=> !pendQ[ALARM_BIT]);
endmodule

// File: rtl/prescaled_alarm_timer.sv
module prescaled_alarm_timer
  import pat_pkg::*;
#(
  parameter int PRESCALE    = 128,
  parameter int SYNC_STAGES = 2,
  parameter int RST_BIT     = 17,
  parameter int PWR_BIT     = 11,
  parameter int ALARM_BIT   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rstBtn,
  input  logic              pwrBtn,
  input  logic [DATA_W-1:0] extIrq,
  output logic              irqOut
);
  patStrobe_t strb;
  patRegs_t   regs;

  pat_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .RST_BIT    (RST_BIT),
    .PWR_BIT    (PWR_BIT),
    .ALARM_BIT  (ALARM_BIT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .rstBtn  (rstBtn),
    .pwrBtn  (pwrBtn),
    .extIrq  (extIrq),
    .regs    (regs),
    .strb    (strb)
  );

  pat_datapath #(
    .PRESCALE (PRESCALE),
    .ALARM_BIT(ALARM_BIT)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .regs  (regs),
    .irqOut(irqOut)
  );
endmodule

// File: tb/prescaled_alarm_timer_tb.sv
module prescaled_alarm_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_TIM = 8'h10, A_ALM = 8'h14, A_STS = 8'h38, A_ENA = 8'h3C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rstBtn = 1'b0, pwrBtn = 1'b0;
  logic [31:0] extIrq = '0;
  logic        irqOut;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prescaled_alarm_timer u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rstBtn(rstBtn), .pwrBtn(pwrBtn), .extIrq(extIrq), .irqOut(irqOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic busRd(logic [7:0] a, output logic [31:0] d);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic waitEdges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    busRd(A_TIM, v); check("R1 timer", v, 0);
    busRd(A_ALM, v); check("R1 alarm", v, 0);
    busRd(A_STS, v); check("R1 pending", v, 0);
    busRd(A_ENA, v); check("R1 enable", v, 0);
    check("R1 irq", irqOut, 0);
  endtask

  task automatic testCount();
    logic [31:0] v;
    busWr(A_TIM, 32'h10);
    waitEdges(128 * 3);
    busRd(A_TIM, v); check("R2 three ticks", v, 32'h13);
    waitEdges(128);
    busRd(A_TIM, v); check("R2 fourth tick", v, 32'h14);
  endtask

  task automatic testLoad();
    logic [31:0] v;
    waitEdges(50);
    busWr(A_TIM, 32'hFFFF_0000);
    waitEdges(127);
    busRd(A_TIM, v); check("R3 hold 127", v, 32'hFFFF_0000);
    waitEdges(1);
    busRd(A_TIM, v); check("R3 step 128", v, 32'hFFFF_0001);
  endtask

  task automatic testAlarm();
    logic [31:0] v;
    busWr(A_ALM, 32'h500);
    busWr(A_TIM, 32'h4FF);
    waitEdges(127);
    busRd(A_STS, v); check("R4 before tick", v & 1, 0);
    waitEdges(1);
    busRd(A_STS, v); check("R4 fired", v & 1, 1);
    busWr(A_STS, 32'h1);
    waitEdges(100);
    busRd(A_TIM, v); check("R4 still equal", v, 32'h500);
    busRd(A_STS, v); check("R4 no refire", v & 1, 0);
  endtask

  task automatic testLoadEqual();
    logic [31:0] v;
    busWr(A_ALM, 32'h777);
    busWr(A_TIM, 32'h777);
    waitEdges(20);
    busRd(A_STS, v); check("R5 load equal", v & 1, 0);
  endtask

  task automatic testButtons();
    logic [31:0] v;
    @(negedge clk); rstBtn = 1;
    waitEdges(5);
    busRd(A_STS, v); check("R7 reset btn", v, 32'h0002_0000);
    check("R9 masked irq", irqOut, 0);
    busWr(A_ENA, 32'h0002_0000);
    check("R9 enabled irq", irqOut, 1);
    busWr(A_STS, 32'h0000_0000);
    busRd(A_STS, v); check("R6 zero write keeps", v, 32'h0002_0000);
    busWr(A_STS, 32'h0002_0000);
    check("R9 irq after clear", irqOut, 0);
    waitEdges(10);
    busRd(A_STS, v); check("R7 held no reset", v, 0);
    @(negedge clk); rstBtn = 0; pwrBtn = 1;
    waitEdges(5);
    busRd(A_STS, v); check("R8 power btn", v, 32'h0000_0800);
    check("R9 other bit masked", irqOut, 0);
    pwrBtn = 0;
    busWr(A_STS, 32'hFFFF_FFFF);
    busRd(A_STS, v); check("R6 all clear", v, 0);
  endtask

  task automatic testExt();
    logic [31:0] v;
    @(negedge clk); extIrq = 32'h0002_0821;
    @(negedge clk); extIrq = 0;
    busRd(A_STS, v); check("R11 ext set and ignore", v, 32'h0000_0020);
    @(negedge clk);
    extIrq = 32'h20; busSel = 1; busWrite = 1; busAddr = A_STS; busWdata = 32'h20;
    @(negedge clk);
    extIrq = 0; busSel = 0; busWrite = 0;
    busRd(A_STS, v); check("R10 set wins", v, 32'h20);
    busWr(A_STS, 32'h20);
    busRd(A_STS, v); check("R6 cleared", v, 0);
  endtask

  task automatic testUnmapped();
    logic [31:0] v;
    busWr(A_ALM, 32'h1234);
    busWr(A_ENA, 32'h0);
    busWr(8'h20, 32'hDEAD_BEEF);
    busRd(8'h20, v); check("R12 unmapped read", v, 0);
    busRd(A_ALM, v); check("R12 alarm untouched", v, 32'h1234);
    busRd(A_ENA, v); check("R12 enable untouched", v, 0);
    busRd(A_STS, v); check("R12 pending untouched", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    waitEdges(2);
    testCount();
    testLoad();
    testAlarm();
    testLoadEqual();
    testButtons();
    testExt();
    testUnmapped();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule